// File: doc/BRIEF.md
# FIFO-Buffered Serial Peripheral Interface Master

This block is a register-mapped SPI master. Software fills an eight-entry transmit queue through a shared data register, then issues a start command. The serial engine shifts characters out MSB first and gathers the incoming bits into an eight-entry receive queue. Reading that same data register pops the received characters.

There is no length register. A transfer lasts until the engine finishes a character that software tagged with an end-of-transfer flag when it queued it. Select stays low between characters and rises once that tagged character has completed. The engine also ends a transfer early if it needs another character and the transmit queue is empty.

The bit clock is divided from the system clock by a six-bit rate field. Clock polarity and sampling phase are programmable. Character length runs from 1 to 16 bits. A sticky event register collects the following conditions:
- completion
- receive overflow
- transmit underflow
- a competing master driving the peer-select input
- queue-threshold requests

Each event reaches the interrupt pin only when its mask bit is clear.

Top module: `spim_top`

## Requirements
- R1: After reset the following hold: `cs_n`=1, `irq`=0, event register (word 3) = 0, mask register (word 4) = 0x3F, status register (word 2) = 0x02. Status bits are: bit0 TX full, bit1 RX empty, bit2 ready, bit3 interrupt pending, bit4 busy.
- R2: Every SCK level lasts exactly (rate+1) system clocks, where rate is configuration bits [5:0]. The SCK frequency is therefore clk/(2*(rate+1)).
- R3: Configuration bit 6 sets the idle SCK level (polarity). Configuration bit 7 set means data is sampled on the second edge of each bit; clear means it is sampled on the first edge. Data is shifted MSB first in both directions, and a peer that follows the same mode exchanges characters intact.
- R4: Configuration bits [11:8] hold the character length minus one. Bit 15 enables the engine.
- R5: Writing the data register (word 5) queues bits [15:0] as a character and bit 16 as its end-of-transfer flag. `cs_n` stays low across untagged characters and rises once after the tagged character. Completion sets event bit 0.
- R6: Control register (word 1) bits self-clear: bit0 flushes RX, bit1 flushes TX, bit2 starts a transfer.
- R7: Status bit2 (ready) follows the enable bit one clock later. Status bit4 is high while a transfer runs.
- R8: Writing 1 to an event-register bit clears it. Writing 0 leaves it unchanged.
- R9: `irq` = OR over events whose mask bit is 0. Status bit3 mirrors `irq`.
- R10: Event bit4 sets when a pop empties the TX queue. Event bit5 sets when a character enters an empty RX queue.
- R11: A read of word 5 returns the oldest received character in bits [15:0] and removes it from the queue.
- R12: A character completing while the RX queue holds 8 entries is dropped and sets event bit1.
- R13: If the engine needs a character (on start, or after an untagged character) and TX is empty, event bit2 sets and select is released.
- R14: With the engine enabled, `peer_sel_n` low sets event bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops RX on word 5) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request, level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Peripheral select, active low |
| peer_sel_n | input | 1 | Select line seen from another master, active low |

## Verification
The hardest state to reach is receive overflow. The transmit queue holds only eight characters, so one transfer can never push a ninth character into a full receive queue. The stimulus therefore runs a tagged eight-character transfer without reading anything back, then starts a second one-character transfer, and checks both that the overflow event is set and that exactly eight characters can be popped, the oldest first. Mode correctness is checked against a bench peer that samples and drives on the edges its own mode model dictates, so a swapped phase shows up as corrupted characters on both sides.

// File: rtl/spim_pkg.sv
// Shared constants for the SPI master: register word indices,
// configuration field positions and event bit indices.
package spim_pkg;
    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_EVT  = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;
    localparam logic [2:0] A_DATA = 3'd5;

    localparam int CFG_POL = 6;
    localparam int CFG_PHA = 7;
    localparam int CFG_LEN = 8;
    localparam int CFG_EN  = 15;
    localparam int TAG_BIT = 16;

    localparam int EV_DONE = 0;
    localparam int EV_OVF  = 1;
    localparam int EV_UNF  = 2;
    localparam int EV_MM   = 3;
    localparam int EV_TXRQ = 4;
    localparam int EV_RXRQ = 5;
    localparam int NUM_EV  = 6;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous FIFO. Assumes a single clock; push when full and pop
// when empty are ignored; clear has priority over push and pop.
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign level   = cnt;

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/spim_shifter.sv
// Serial engine: rate divider, mode-dependent edge handling, MSB-first
// shift registers and transfer sequencing by the end-of-transfer tag.
// Assumes CHAR_MAX is a power of two and tx_word is valid while tx_valid.
module spim_shifter #(
    parameter int CHAR_MAX = 16,
    parameter int BRG_W    = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [BRG_W-1:0]          rate,
    input  logic                      cpol,
    input  logic                      cpha,
    input  logic [$clog2(CHAR_MAX)-1:0] len_m1,
    input  logic                      go,
    input  logic                      tx_valid,
    input  logic [CHAR_MAX:0]         tx_word,
    output logic                      tx_pop,
    output logic                      rx_push,
    output logic [CHAR_MAX-1:0]       rx_word,
    output logic                      done,
    output logic                      underrun,
    output logic                      busy,
    output logic                      sck,
    output logic                      mosi,
    input  logic                      miso,
    output logic                      cs_n
);
    localparam int LEN_W = $clog2(CHAR_MAX);

    logic [BRG_W-1:0]    cnt;
    logic [LEN_W:0]      ecnt;
    logic [CHAR_MAX-1:0] txsr, rxsr, rx_next, load_val;
    logic [LEN_W-1:0]    sh;
    logic                busy_q, cs_q, sck_q, tag_q;
    logic                tick, lead, edge_end, sample, shift, start_ok, chain;

    assign sh       = LEN_W'(CHAR_MAX-1) - len_m1;
    assign load_val = tx_word[CHAR_MAX-1:0] << sh;
    assign tick     = busy_q && (cnt == rate);
    assign lead     = ~ecnt[0];
    assign edge_end = (ecnt == {len_m1, 1'b1});
    assign sample   = tick && (lead ^ cpha);
    assign shift    = tick && !(lead ^ cpha) && !(cpha && ecnt == '0);
    assign rx_next  = sample ? {rxsr[CHAR_MAX-2:0], miso} : rxsr;
    assign start_ok = en && !busy_q && go && tx_valid;
    assign chain    = tick && edge_end && !tag_q;

    assign tx_pop   = start_ok || (chain && tx_valid);
    assign underrun = (en && !busy_q && go && !tx_valid) || (chain && !tx_valid);
    assign done     = tick && edge_end && tag_q;
    assign rx_push  = tick && edge_end;
    assign rx_word  = rx_next & ({CHAR_MAX{1'b1}} >> sh);
    assign busy     = busy_q;
    assign sck      = sck_q;
    assign cs_n     = cs_q;
    assign mosi     = busy_q & txsr[CHAR_MAX-1];

    // Idle/launch, bit-edge stepping and character chaining
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; cs_q <= 1'b1; sck_q <= 1'b0; tag_q <= 1'b0;
            cnt <= '0; ecnt <= '0; txsr <= '0; rxsr <= '0;
        end else if (!en || !busy_q) begin
            sck_q <= cpol;
            cnt   <= '0;
            ecnt  <= '0;
            busy_q <= start_ok;
            cs_q   <= !start_ok;
            if (start_ok) begin
                txsr  <= load_val;
                tag_q <= tx_word[CHAR_MAX];
                rxsr  <= '0;
            end
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
                sck_q <= ~sck_q;
                rxsr  <= rx_next;
                if (edge_end) begin
                    ecnt <= '0;
                    if (!tag_q && tx_valid) begin
                        txsr  <= load_val;
                        tag_q <= tx_word[CHAR_MAX];
                    end else begin
                        busy_q <= 1'b0;
                        cs_q   <= 1'b1;
                    end
                end else begin
                    ecnt <= ecnt + 1'b1;
                    if (shift) txsr <= txsr << 1;
                end
            end
        end
    end
endmodule

// File: rtl/spim_top.sv
// Register-mapped SPI master top: register file, event/mask logic,
// TX/RX queues and the serial engine. Assumes a single clock domain
// and that peer_sel_n and miso are already synchronised.
module spim_top #(
    parameter int FIFO_DEPTH = 8,
    parameter int CHAR_MAX   = 16,
    parameter int BRG_W      = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    input  logic        peer_sel_n
);
    import spim_pkg::*;
    localparam int LEN_W = $clog2(CHAR_MAX);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    logic [15:0]          cfg_q;
    logic [NUM_EV-1:0]    evt_q, mask_q, ev_set, ev_clr;
    logic                 ready_q, en, cpol, go;
    logic                 tx_clr, rx_clr, tx_push, rx_pop;
    logic                 tx_empty, tx_full, rx_empty, rx_full;
    logic [CHAR_MAX:0]    tx_head;
    logic [CHAR_MAX-1:0]  rx_head, rx_word;
    logic [LVL_W-1:0]     tx_level, rx_level_unused;
    logic                 tx_pop, rx_push, done_pulse, unf_pulse, shf_busy;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[31:17];
    assign en     = cfg_q[CFG_EN];
    assign cpol   = cfg_q[CFG_POL];
    assign go     = bus_we && bus_addr == A_CTRL && bus_wdata[2];
    assign rx_clr = bus_we && bus_addr == A_CTRL && bus_wdata[0];
    assign tx_clr = bus_we && bus_addr == A_CTRL && bus_wdata[1];
    assign tx_push = bus_we && bus_addr == A_DATA;
    assign rx_pop  = bus_re && bus_addr == A_DATA;
    assign ev_clr  = (bus_we && bus_addr == A_EVT) ? bus_wdata[NUM_EV-1:0] : '0;
    assign irq     = |(evt_q & ~mask_q);

    // Event sources
    always_comb begin
        ev_set          = '0;
        ev_set[EV_DONE] = done_pulse;
        ev_set[EV_OVF]  = rx_push && rx_full;
        ev_set[EV_UNF]  = unf_pulse;
        ev_set[EV_MM]   = en && !peer_sel_n;
        ev_set[EV_TXRQ] = tx_pop && !tx_empty && tx_level == LVL_W'(1);
        ev_set[EV_RXRQ] = rx_push && rx_empty;
    end

    // Configuration, mask, ready and sticky events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            mask_q  <= '1;
            evt_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            if (bus_we && bus_addr == A_CFG)  cfg_q  <= bus_wdata[15:0];
            if (bus_we && bus_addr == A_MASK) mask_q <= bus_wdata[NUM_EV-1:0];
            evt_q   <= (evt_q & ~ev_clr) | ev_set;
            ready_q <= en;
        end
    end

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG:  bus_rdata[15:0] = cfg_q;
            A_STAT: bus_rdata[4:0]  = {shf_busy, irq, ready_q, rx_empty, tx_full};
            A_EVT:  bus_rdata[NUM_EV-1:0] = evt_q;
            A_MASK: bus_rdata[NUM_EV-1:0] = mask_q;
            A_DATA: bus_rdata[CHAR_MAX-1:0] = rx_head;
            default: bus_rdata = '0;
        endcase
    end

    spim_fifo #(.W(CHAR_MAX+1), .DEPTH(FIFO_DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .din({bus_wdata[TAG_BIT], bus_wdata[CHAR_MAX-1:0]}),
        .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full),
        .level(tx_level));

    spim_fifo #(.W(CHAR_MAX), .DEPTH(FIFO_DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full),
        .level(rx_level_unused));

    spim_shifter #(.CHAR_MAX(CHAR_MAX), .BRG_W(BRG_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .rate(cfg_q[BRG_W-1:0]), .cpol(cpol), .cpha(cfg_q[CFG_PHA]),
        .len_m1(cfg_q[CFG_LEN +: LEN_W]), .go(go),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .done(done_pulse), .underrun(unf_pulse), .busy(shf_busy),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));
endmodule

// File: rtl/spim_checker.sv
// Temporal checks on the SPI master, bound into spim_top.
module spim_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       irq,
    input logic       cpol,
    input logic       en,
    input logic       go,
    input logic       busy,
    input logic       tx_empty,
    input logic       rx_push,
    input logic       rx_full,
    input logic       done_pulse,
    input logic       peer_sel_n,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [5:0] evt
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (cs_n && !irq)); // R1
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $stable(cpol)) |-> (sck == cpol)); // R3
    AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd3 && bus_wdata[0] && !done_pulse) |=> !evt[0]); // R8
    AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> evt[1]); // R12
    AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (go && en && !busy && tx_empty) |=> evt[2]); // R13
    AST_PEER_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !peer_sel_n) |=> evt[3]); // R14
endmodule

bind spim_top spim_checker chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .irq(irq),
    .cpol(cpol), .en(en), .go(go), .busy(shf_busy), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_full(rx_full), .done_pulse(done_pulse),
    .peer_sel_n(peer_sel_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .evt(evt_q));

// File: tb/spim_top_tb_top.sv
`timescale 1ns/1ps
module spim_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sck, mosi, cs_n;
    logic        miso = 1'b0;
    logic        peer_sel_n = 1'b1;

    int n_chk = 0, n_fail = 0;
    localparam logic [31:0] PAT = 32'hC3A5_96E1;

    // rate, cpol, cpha, len-1, char
    localparam logic [27:0] ROWS [6] = '{
        {6'd0, 1'b0, 1'b0, 4'd7,  16'h00A5},
        {6'd1, 1'b0, 1'b1, 4'd7,  16'h003C},
        {6'd2, 1'b1, 1'b0, 4'd7,  16'h0081},
        {6'd0, 1'b1, 1'b1, 4'd7,  16'h00F0},
        {6'd3, 1'b0, 1'b0, 4'd3,  16'h0009},
        {6'd1, 1'b1, 1'b1, 4'd15, 16'hBEEF}
    };

    always #2 clk = ~clk;

    spim_top dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .peer_sel_n(peer_sel_n));

    // Bench peer: mode model, half-period monitor, select-rise counter
    logic        b_cpol = 1'b0, b_cpha = 1'b0;
    int          b_half = 1;
    int          sl_idx = 0;
    logic [15:0] sl_rx = '0;
    logic        mosi_d = 1'b0, cs_d = 1'b1;
    time         last_t = 0;
    bit          have_last = 0, hp_bad = 0;
    int          cs_rises = 0;

    always @(negedge clk) begin mosi_d <= mosi; cs_d <= cs_n; end
    always @(posedge cs_n) cs_rises++;
    always @(negedge cs_n) begin
        sl_rx = '0; have_last = 0;
        if (!b_cpha) begin miso = PAT[31]; sl_idx = 30; end
        else sl_idx = 31;
    end
    always @(sck) begin
        if (!cs_d) begin
            if ((sck !== b_cpol) ^ b_cpha) sl_rx = {sl_rx[14:0], mosi_d};
            else begin
                miso = (sl_idx >= 0) ? PAT[sl_idx] : 1'b0;
                sl_idx--;
            end
            if (have_last && (($time - last_t) / 4) != b_half) hp_bad = 1;
            last_t = $time; have_last = 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_re = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd2, s);
            if (!s[4]) break;
        end
    endtask

    task automatic cfg(input logic [5:0] r, input logic p, input logic h, input logic [3:0] l);
        b_cpol = p; b_cpha = h; b_half = r + 1;
        wr(3'd0, {16'h0, 1'b1, 3'b0, l, h, p, r});
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {31'b0, cs_n}, 1); chk("R1 irq", {31'b0, irq}, 0);
        rd(3'd2, v); chk("R1 status", v, 32'h2);
        rd(3'd3, v); chk("R1 events", v, 0);
        rd(3'd4, v); chk("R1 mask", v, 32'h3F);
        // R7 ready follows enable
        cfg(6'd0, 1'b0, 1'b0, 4'd7);
        rd(3'd2, v); chk("R7 ready", {31'b0, v[2]}, 1);

        // Vector table walk
        foreach (ROWS[i]) begin
            logic [5:0] r; logic p, h; logic [3:0] l; logic [15:0] t;
            {r, p, h, l, t} = ROWS[i];
            cfg(r, p, h, l);
            chk("R3 idle sck", {31'b0, sck}, {31'b0, p});
            wr(3'd3, 32'h3F);
            hp_bad = 0;
            wr(3'd5, {15'b0, 1'b1, t});
            wr(3'd1, 32'h4);
            wait_idle();
            chk("R3 peer got char", {16'b0, sl_rx & (16'hFFFF >> (15 - l))}, {16'b0, t});
            rd(3'd5, v); chk("R4 rx char", v, PAT >> (31 - l));
            chk("R2 half period", {31'b0, hp_bad}, 0);
            chk("R5 cs released", {31'b0, cs_n}, 1);
            rd(3'd3, v); chk("R10 done+requests", v, 32'h31);
            wr(3'd3, 32'h1);
            rd(3'd3, v); chk("R8 w1c one bit", v, 32'h30);
            wr(3'd4, 32'h2F);
            @(negedge clk); chk("R9 irq unmasked", {31'b0, irq}, 1);
            rd(3'd2, v); chk("R9 pending bit", {31'b0, v[3]}, 1);
            wr(3'd4, 32'h3F);
            @(negedge clk); chk("R9 irq masked", {31'b0, irq}, 0);
        end

        // R5 / R11 two-character transfer
        cfg(6'd1, 1'b0, 1'b0, 4'd7);
        wr(3'd3, 32'h3F);
        wr(3'd5, 32'h0012); wr(3'd5, 32'h1_0034);
        c0 = cs_rises;
        wr(3'd1, 32'h4);
        wait_idle();
        chk("R5 single select rise", cs_rises - c0, 1);
        chk("R5 peer stream", {16'b0, sl_rx}, 32'h1234);
        rd(3'd3, v); chk("R5 done event", {31'b0, v[0]}, 1);
        rd(3'd5, v); chk("R11 first pop", v, 32'hC3);
        rd(3'd5, v); chk("R11 second pop", v, 32'hA5);
        rd(3'd2, v); chk("R11 rx empty", {31'b0, v[1]}, 1);

        // R12 overflow: eight characters, then one more
        wr(3'd3, 32'h3F);
        for (int k = 0; k < 8; k++) wr(3'd5, {15'b0, k == 7, 16'h10 + 16'(k)});
        wr(3'd1, 32'h4); wait_idle();
        rd(3'd3, v); chk("R12 no overflow yet", {31'b0, v[1]}, 0);
        wr(3'd5, 32'h1_0077); wr(3'd1, 32'h4); wait_idle();
        rd(3'd3, v); chk("R12 overflow event", {31'b0, v[1]}, 1);
        rd(3'd5, v); chk("R12 oldest kept", v, 32'hC3);
        for (int k = 0; k < 7; k++) rd(3'd5, v);
        rd(3'd2, v); chk("R12 ninth dropped", {31'b0, v[1]}, 1);

        // R13 underflow: untagged char, then start on empty queue
        wr(3'd3, 32'h3F);
        wr(3'd5, 32'h0055); wr(3'd1, 32'h4); wait_idle();
        rd(3'd3, v); chk("R13 underflow mid", v[2:0], 3'b100);
        chk("R13 select released", {31'b0, cs_n}, 1);
        wr(3'd3, 32'h3F);
        wr(3'd1, 32'h4);
        rd(3'd3, v); chk("R13 underflow on start", {31'b0, v[2]}, 1);

        // R6 flushes
        rd(3'd2, v); chk("R6 rx holds char", {31'b0, v[1]}, 0);
        wr(3'd1, 32'h1);
        rd(3'd2, v); chk("R6 rx flushed", {31'b0, v[1]}, 1);
        for (int k = 0; k < 3; k++) wr(3'd5, 32'h0);
        wr(3'd1, 32'h2);
        for (int k = 0; k < 7; k++) wr(3'd5, 32'h0);
        rd(3'd2, v); chk("R6 tx flushed", {31'b0, v[0]}, 0);
        wr(3'd5, 32'h0);
        rd(3'd2, v); chk("R7 tx full", {31'b0, v[0]}, 1);
        wr(3'd1, 32'h2);

        // R14 competing master
        wr(3'd3, 32'h3F);
        @(negedge clk); peer_sel_n = 1'b0;
        repeat (2) @(negedge clk); peer_sel_n = 1'b1;
        rd(3'd3, v); chk("R14 peer event", {31'b0, v[3]}, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule